// File: doc/BRIEF.md
# Mixed-Width Register Access Splitter

This block adapts a CPU request port to a bank of peripheral registers whose native width varies from one 4-byte slot to the next. The CPU issues byte, word or long requests. The splitter asks an external slot table for the native width of the addressed slot. It then turns the request into one or more native-width accesses on the register side and issues them one at a time. Requests wider than the register are cut into a big-endian run of native accesses. Reads narrower than the register fetch the whole register and pick out the addressed lane. Writes narrower than the register fetch the register, patch the addressed lane and store the result back.

The table contents and the decoding of individual registers lie outside the block. Every register-side access is a request/acknowledge pair. The CPU sees a single one-cycle completion pulse once the last sub-access has been acknowledged. That pulse also carries an error flag for offsets outside the decoded window.

Top module: `width_split_bridge`

## Requirements
- R1: Only bits 9:0 of `cpuAddr` form the bus offset. Two addresses that differ only above bit 9 produce identical register-side accesses.
- R2: An offset of 0x200 or more completes with `cpuErr`=1 and `cpuRdata`=0. It issues no register access and changes no register.
- R3: `slotIdx` carries `cpuAddr[9:2]`. The returned `slotCode` and the request `cpuSize` share one encoding: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Code 3 is handled as 4 bytes. Every register-side access uses the native size of the addressed slot.
- R4: The offset is aligned to the request size: bit 0 is cleared for words, and bits 1:0 are cleared for longs. When the request size equals the native size, exactly one access of that size is issued at the aligned offset.
- R5: A request wider than the native width becomes 2^(size-native) native accesses at ascending offsets, each step one native width. The first access carries the most significant part of the write data. Read data is assembled with the first access in the most significant position.
- R6: A read narrower than the native width issues one native read at the offset aligned to the native width. It returns the addressed lane, numbered big-endian, so the lowest address sits in the most significant bits.
- R7: A write narrower than the native width issues one native read and then one native write to the same offset. The written value equals the value read with only the addressed lane replaced.
- R8: `regReq` stays high with `regAddr`, `regSize`, `regWe` and `regWdata` unchanged until `regAck`. Within one request, sub-access offsets never decrease.
- R9: `cpuReady` is a one-cycle pulse after the final acknowledge. `cpuRdata` is right-justified, with bits above the request size zero, and it is zero for writes.
- R10: `regReq` is low while the block waits for a request and in the cycle `cpuReady` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Request strobe, sampled while idle |
| cpuAddr | input | ADDR_W | Request address; only the low OFFS_W bits are used |
| cpuSize | input | 2 | Request size code |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuWdata | input | 32 | Right-justified write data |
| cpuRdata | output | 32 | Right-justified read data, valid with cpuReady |
| cpuReady | output | 1 | Completion pulse |
| cpuErr | output | 1 | Out-of-range flag, valid with cpuReady |
| slotIdx | output | OFFS_W-2 | Slot index presented to the width table |
| slotCode | input | 2 | Native width code returned by the table |
| regReq | output | 1 | Register-side access request |
| regAddr | output | OFFS_W | Register-side offset |
| regSize | output | 2 | Register-side access size code |
| regWe | output | 1 | Register-side write enable |
| regWdata | output | 32 | Right-justified register write data |
| regRdata | input | 32 | Right-justified register read data, valid with regAck |
| regAck | input | 1 | Register-side acknowledge |

## Verification
The bench sweeps every offset of sixteen slots, covering byte, word and long slots and one slot that returns code 3. Each offset is tried with every request size, so the equal, splitting and narrowing cases each appear with every lane position. Plain reads of a seeded register image check lane numbering and the order in which split data is assembled. Each write is followed by a read-back of the same request and a comparison of the whole register image, which shows whether a read-modify-write disturbed neighbouring lanes or a split put its halves in the wrong order. Requests with high address bits, the size code 3, and offsets past the window check masking, clamping and the error path, which must leave the register image untouched.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {PH_NONE, PH_SPLIT, PH_READ, PH_WRITE} phase_e;

  typedef struct packed {
    logic       load;
    logic       accStep;
    logic       bufLoad;
    phase_e     phase;
    logic [1:0] subIdx;
  } strobe_t;

  typedef struct packed {
    logic [1:0] sz;
    logic [1:0] nat;
    logic       we;
    logic       err;
  } xfer_t;

  function automatic logic [DATA_W-1:0] laneMask(input logic [1:0] code);
    case (code)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // index of the last lane when a value of 2^diff lanes is walked
  function automatic logic [1:0] lastLaneOf(input logic [1:0] diff);
    case (diff)
      2'd1:    return 2'd1;
      2'd2:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/wsb_ctrl.sv
module wsb_ctrl
  import wsb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cpuReq,
  input  logic    regAck,
  input  xfer_t   xfer,
  output strobe_t strb,
  output logic    regReq,
  output logic    cpuReady
);
  typedef enum logic [2:0] {ST_IDLE, ST_DECIDE, ST_SPLIT, ST_READ, ST_WRITE, ST_DONE} state_e;

  state_e     state, stateNxt;
  logic [1:0] subIdx, subNxt, lastIdx;

  assign lastIdx = lastLaneOf(xfer.sz - xfer.nat);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      subIdx <= 2'd0;
    end else begin
      state  <= stateNxt;
      subIdx <= subNxt;
    end
  end

  always_comb begin
    strb        = '0;
    strb.phase  = PH_NONE;
    strb.subIdx = subIdx;
    regReq      = 1'b0;
    cpuReady    = 1'b0;
    stateNxt    = state;
    subNxt      = subIdx;
    case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          strb.load = 1'b1;
          stateNxt  = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        subNxt = 2'd0;
        if (xfer.err)                stateNxt = ST_DONE;
        else if (xfer.sz >= xfer.nat) stateNxt = ST_SPLIT;
        else                         stateNxt = ST_READ;
      end
      ST_SPLIT: begin
        strb.phase = PH_SPLIT;
        regReq     = 1'b1;
        if (regAck) begin
          strb.accStep = 1'b1;
          if (subIdx == lastIdx) stateNxt = ST_DONE;
          else                   subNxt   = subIdx + 2'd1;
        end
      end
      ST_READ: begin
        strb.phase = PH_READ;
        regReq     = 1'b1;
        if (regAck) begin
          strb.bufLoad = 1'b1;
          stateNxt     = xfer.we ? ST_WRITE : ST_DONE;
        end
      end
      ST_WRITE: begin
        strb.phase = PH_WRITE;
        regReq     = 1'b1;
        if (regAck) stateNxt = ST_DONE;
      end
      ST_DONE: begin
        cpuReady = 1'b1;
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/wsb_datapath.sv
module wsb_datapath
  import wsb_pkg::*;
#(
  parameter int OFFS_W = 10,
  parameter int LIMIT  = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [OFFS_W-1:0] cpuOffs,
  input  logic [1:0]        cpuSize,
  input  logic              cpuWe,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [1:0]        slotCode,
  input  logic [DATA_W-1:0] regRdata,
  output xfer_t             xfer,
  output logic [OFFS_W-1:0] regAddr,
  output logic [1:0]        regSize,
  output logic              regWe,
  output logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] cpuRdata
);
  logic [OFFS_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, accQ, bufQ;
  logic [1:0]        szQ, natQ;
  logic              weQ, errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      accQ   <= '0;
      bufQ   <= '0;
      szQ    <= 2'd0;
      natQ   <= 2'd0;
      weQ    <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      if (strb.load) begin
        addrQ  <= cpuOffs;
        wdataQ <= cpuWdata;
        szQ    <= (cpuSize == 2'd3) ? 2'd2 : cpuSize;
        natQ   <= (slotCode == 2'd3) ? 2'd2 : slotCode;
        weQ    <= cpuWe;
        errQ   <= (cpuOffs >= OFFS_W'(LIMIT));
        accQ   <= '0;
      end
      if (strb.accStep)
        accQ <= (accQ << (6'd8 << natQ)) | (regRdata & laneMask(natQ));
      if (strb.bufLoad)
        bufQ <= regRdata;
    end
  end

  assign xfer = '{sz: szQ, nat: natQ, we: weQ, err: errQ};

  // alignment masks for the request size and the native size
  logic [OFFS_W-1:0] szAlign, natAlign;
  assign szAlign  = ~((OFFS_W'(1) << szQ) - OFFS_W'(1));
  assign natAlign = ~((OFFS_W'(1) << natQ) - OFFS_W'(1));

  // split: the first sub-access takes the most significant lane
  logic [1:0] splitLast;
  logic [6:0] splitShift;
  assign splitLast  = lastLaneOf(szQ - natQ);
  assign splitShift = 7'({(splitLast - strb.subIdx), 3'b000}) << natQ;

  // narrow: lane j of the native register, lane 0 most significant
  logic [1:0] laneLast, laneIdx, natLow;
  logic [6:0] laneShift;
  assign natLow    = {natQ[1], |natQ};
  assign laneIdx   = (addrQ[1:0] & natLow) >> szQ;
  assign laneLast  = lastLaneOf(natQ - szQ);
  assign laneShift = 7'({(laneLast - laneIdx), 3'b000}) << szQ;

  always_comb begin
    regSize = natQ;
    case (strb.phase)
      PH_SPLIT: begin
        regAddr  = (addrQ & szAlign) + (OFFS_W'(strb.subIdx) << natQ);
        regWdata = (wdataQ >> splitShift) & laneMask(natQ);
        regWe    = weQ;
      end
      PH_WRITE: begin
        regAddr  = addrQ & natAlign;
        regWdata = (bufQ & ~(laneMask(szQ) << laneShift))
                 | ((wdataQ & laneMask(szQ)) << laneShift);
        regWe    = 1'b1;
      end
      default: begin
        regAddr  = addrQ & natAlign;
        regWdata = '0;
        regWe    = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (errQ || weQ)      cpuRdata = '0;
    else if (szQ >= natQ) cpuRdata = accQ;
    else                  cpuRdata = (bufQ >> laneShift) & laneMask(szQ);
  end
endmodule

// File: rtl/width_split_bridge.sv
module width_split_bridge
  import wsb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 10,
  parameter int LIMIT  = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [1:0]        cpuSize,
  input  logic              cpuWe,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuReady,
  output logic              cpuErr,
  output logic [OFFS_W-3:0] slotIdx,
  input  logic [1:0]        slotCode,
  output logic              regReq,
  output logic [OFFS_W-1:0] regAddr,
  output logic [1:0]        regSize,
  output logic              regWe,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata,
  input  logic              regAck
);
  strobe_t strb;
  xfer_t   xfer;
  logic    unusedAddrHi;

  assign unusedAddrHi = ^cpuAddr[ADDR_W-1:OFFS_W];
  assign slotIdx      = cpuAddr[OFFS_W-1:2];
  assign cpuErr       = cpuReady & xfer.err;

  wsb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuReq   (cpuReq),
    .regAck   (regAck),
    .xfer     (xfer),
    .strb     (strb),
    .regReq   (regReq),
    .cpuReady (cpuReady)
  );

  wsb_datapath #(.OFFS_W(OFFS_W), .LIMIT(LIMIT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cpuOffs  (cpuAddr[OFFS_W-1:0]),
    .cpuSize  (cpuSize),
    .cpuWe    (cpuWe),
    .cpuWdata (cpuWdata),
    .slotCode (slotCode),
    .regRdata (regRdata),
    .xfer     (xfer),
    .regAddr  (regAddr),
    .regSize  (regSize),
    .regWe    (regWe),
    .regWdata (regWdata),
    .cpuRdata (cpuRdata)
  );
endmodule

// File: rtl/wsb_checker.sv
module wsb_checker #(
  parameter int OFFS_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReady,
  input logic              cpuErr,
  input logic [31:0]       cpuRdata,
  input logic              regReq,
  input logic              regAck,
  input logic [OFFS_W-1:0] regAddr,
  input logic [1:0]        regSize,
  input logic              regWe,
  input logic [31:0]       regWdata
);
  logic [OFFS_W-1:0] lastAddr;
  logic [1:0]        firstSize;
  logic              haveAck;
  logic [3:0]        ackCnt;

  always_ff @(posedge clk) begin
    if (!rstN || cpuReady) begin
      lastAddr  <= '0;
      firstSize <= 2'd0;
      haveAck   <= 1'b0;
      ackCnt    <= 4'd0;
    end else if (regReq && regAck) begin
      lastAddr  <= regAddr;
      firstSize <= regSize;
      haveAck   <= 1'b1;
      ackCnt    <= (ackCnt == 4'hF) ? ackCnt : ackCnt + 4'd1;
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    regReq && !regAck |=> regReq && $stable(regAddr) && $stable(regSize)
                          && $stable(regWe) && $stable(regWdata));

  // R8
  addr_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    regReq && regAck && haveAck |-> regAddr >= lastAddr);

  // R3
  size_same_chk: assert property (@(posedge clk) disable iff (!rstN)
    regReq && regAck && haveAck |-> regSize == firstSize);

  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);

  // R10
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> !regReq);

  // R2
  err_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady && cpuErr |-> ackCnt == 4'd0 && cpuRdata == 32'd0);
endmodule

bind width_split_bridge wsb_checker #(.OFFS_W(OFFS_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuReady (cpuReady),
  .cpuErr   (cpuErr),
  .cpuRdata (cpuRdata),
  .regReq   (regReq),
  .regAck   (regAck),
  .regAddr  (regAddr),
  .regSize  (regSize),
  .regWe    (regWe),
  .regWdata (regWdata)
);

// File: tb/width_split_bridge_tb.sv
module width_split_bridge_tb;
  localparam int OFFS_W = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic [1:0]  cpuSize = '0;
  logic        cpuWe = 1'b0;
  logic [31:0] cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic        cpuReady, cpuErr;
  logic [OFFS_W-3:0] slotIdx;
  logic [1:0]  slotCode;
  logic        regReq, regWe;
  logic [OFFS_W-1:0] regAddr;
  logic [1:0]  regSize;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic        regAck;

  always #4 clk = ~clk;

  width_split_bridge u_dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuAddr(cpuAddr), .cpuSize(cpuSize),
    .cpuWe(cpuWe), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .cpuErr(cpuErr), .slotIdx(slotIdx), .slotCode(slotCode), .regReq(regReq),
    .regAddr(regAddr), .regSize(regSize), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .regAck(regAck)
  );

  int nChecks = 0;
  int nFails  = 0;

  logic [7:0]        regMem [0:1023];
  logic [7:0]        shadow [0:1023];
  logic [OFFS_W-1:0] logA [0:63];
  logic [1:0]        logS [0:63];
  logic              logW [0:63];
  int                logN;
  logic [31:0]       mdlRd;

  function automatic logic [1:0] codeOf(input int idx);
    return (idx == 15) ? 2'd3 : 2'(idx % 3);
  endfunction

  function automatic logic [7:0] seedOf(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  always_comb slotCode = codeOf(int'(slotIdx));

  // register bank model: acknowledges one cycle after a fresh request
  always @(posedge clk) begin
    if (!rstN) begin
      regAck   <= 1'b0;
      regRdata <= '0;
      logN     <= 0;
      for (int i = 0; i < 1024; i++) regMem[i] <= seedOf(i);
    end else if (regReq && !regAck) begin
      mdlRd = '0;
      for (int b = 0; b < (1 << regSize); b++)
        mdlRd = (mdlRd << 8) | 32'(regMem[10'(int'(regAddr) + b)]);
      if (regWe)
        for (int b = 0; b < (1 << regSize); b++)
          regMem[10'(int'(regAddr) + b)] <= 8'(regWdata >> (8 * ((1 << regSize) - 1 - b)));
      regAck   <= 1'b1;
      regRdata <= mdlRd;
      logA[6'(logN)] <= regAddr;
      logS[6'(logN)] <= regSize;
      logW[6'(logN)] <= regWe;
      logN <= logN + 1;
    end else begin
      regAck <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] addr, input logic [1:0] sz, input bit we, input logic [31:0] wd);
    logic [31:0] rd, expRd;
    bit          err;
    int          startN, nSub, expN, off, szB, natB, base, abase, idx;
    logic [1:0]  nat, szE;
    string       tag;
    off  = int'(addr[9:0]);
    szE  = (sz == 2'd3) ? 2'd2 : sz;
    nat  = codeOf(off >> 2);
    if (nat == 2'd3) nat = 2'd2;
    @(negedge clk);
    startN   = logN;
    cpuReq   = 1'b1;
    cpuAddr  = addr;
    cpuSize  = sz;
    cpuWe    = we;
    cpuWdata = wd;
    @(negedge clk);
    cpuReq = 1'b0;
    do @(negedge clk); while (!cpuReady);
    rd   = cpuRdata;
    err  = cpuErr;
    nSub = logN - startN;
    check(!regReq, "R10 req during ready", 32'(regReq), 32'd0);
    if (off >= 512) begin
      check(err == 1'b1, "R2 err flag", 32'(err), 32'd1);
      check(rd == 32'd0, "R2 rdata", rd, 32'd0);
      check(nSub == 0, "R2 no access", 32'(nSub), 32'd0);
      return;
    end
    check(err == 1'b0, "R2 spurious err", 32'(err), 32'd0);
    if (szE == nat)     tag = "R4";
    else if (szE > nat) tag = "R5";
    else if (we)        tag = "R7";
    else                tag = "R6";
    if (addr[31:10] != 22'd0) tag = "R1";
    szB = 1 << szE;
    natB = 1 << nat;
    if (szE >= nat) begin
      expN = 1 << (szE - nat);
      base = off & ~(szB - 1);
    end else begin
      expN = we ? 2 : 1;
      base = off & ~(natB - 1);
    end
    check(nSub == expN, {tag, " access count"}, 32'(nSub), 32'(expN));
    for (int i = 0; i < expN && i < nSub; i++) begin
      idx = (startN + i) % 64;
      if (szE >= nat) begin
        check(int'(logA[idx]) == base + i * natB, {tag, " sub addr"}, 32'(logA[idx]), 32'(base + i * natB));
        check(logW[idx] == we, {tag, " sub dir"}, 32'(logW[idx]), 32'(we));
      end else begin
        check(int'(logA[idx]) == base, {tag, " rmw addr"}, 32'(logA[idx]), 32'(base));
        check(logW[idx] == (i == 1), {tag, " rmw dir"}, 32'(logW[idx]), 32'(i == 1));
      end
      check(logS[idx] == nat, "R3 native size", 32'(logS[idx]), 32'(nat));
    end
    abase = off & ~(szB - 1);
    if (!we) begin
      expRd = '0;
      for (int b = 0; b < szB; b++) expRd = (expRd << 8) | 32'(shadow[10'(abase + b)]);
      check(rd == expRd, {tag, " read data"}, rd, expRd);
      if (szE != 2'd2)
        check((rd >> (8 * szB)) == 32'd0, "R9 upper bits", rd, expRd);
    end else begin
      check(rd == 32'd0, "R9 write rdata", rd, 32'd0);
      for (int b = 0; b < szB; b++) shadow[10'(abase + b)] = 8'(wd >> (8 * (szB - 1 - b)));
    end
  endtask

  task automatic compareImage(input int lo, input int hi, input string tag);
    for (int i = lo; i <= hi; i++)
      check(regMem[10'(i)] == shadow[10'(i)], tag, 32'(regMem[10'(i)]), 32'(shadow[10'(i)]));
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) shadow[i] = seedOf(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!cpuReady, "R9 reset ready", 32'(cpuReady), 32'd0);
    check(!regReq, "R10 reset req", 32'(regReq), 32'd0);
    check(!cpuErr, "R2 reset err", 32'(cpuErr), 32'd0);

    // read sweep over sixteen slots, every size and offset
    for (int a = 0; a < 64; a++)
      for (int s = 0; s < 3; s++)
        run(32'(a), 2'(s), 1'b0, 32'd0);

    // write then read back, every size and offset
    for (int a = 0; a < 64; a++)
      for (int s = 0; s < 3; s++) begin
        run(32'(a), 2'(s), 1'b1, 32'h9E37_79B9 * 32'(a * 3 + s + 1));
        run(32'(a), 2'(s), 1'b0, 32'd0);
      end
    compareImage(0, 63, "R7 image after writes");

    // size code 3 acts as long (R3)
    run(32'h0000_0020, 2'd3, 1'b0, 32'd0);
    run(32'h0000_0024, 2'd3, 1'b1, 32'hCAFE_F00D);
    run(32'h0000_0024, 2'd2, 1'b0, 32'd0);

    // high address bits ignored (R1)
    run(32'hABCD_0404, 2'd1, 1'b0, 32'd0);
    run(32'h0000_0C41, 2'd0, 1'b1, 32'h0000_005A);
    run(32'h0000_0041, 2'd0, 1'b0, 32'd0);
    run(32'h7FFF_FC7C, 2'd2, 1'b1, 32'h1234_5678);
    run(32'h0000_007C, 2'd2, 1'b0, 32'd0);
    compareImage(64, 127, "R1 image after masked writes");

    // out-of-range offsets (R2)
    run(32'h0000_0200, 2'd2, 1'b0, 32'd0);
    run(32'h0000_03FF, 2'd0, 1'b1, 32'h0000_00EE);
    run(32'h0000_02FE, 2'd1, 1'b1, 32'h0000_BEEF);
    run(32'hFFFF_FE00, 2'd0, 1'b0, 32'd0);
    compareImage(508, 1023, "R2 image untouched");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule